// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block forms the word that a parallel NOR flash model returns on reads while an internal program or erase is in flight, and hands back plain array data once the device has gone idle. Two completion indicators run side by side: bit 7 reports the inverse of the bit being written during a program and a zero during an erase, and bit 6 inverts on every new read for as long as the operation lasts. A host can therefore poll either bit to find the end of a write.

The operation timing is supplied from outside through a busy input, together with a flag that tells program from erase and the latched bit 7 of the word being programmed. Array storage and command decoding sit in neighbouring blocks. A synchronous edge detector on the read strobe counts reads, so one long read inverts bit 6 only once. The status word is registered, and the bus drive is modelled as a registered output-enable flag.

Top module: `wstat_gen`

## Requirements
- R1: After reset the data output is all zero and the output enable is 0.
- R2: The output enable equals 1 exactly when both chip select and output select (active low) were low at the previous clock edge.
- R3: A read that starts while busy during a program (erase flag 0) returns bit 7 equal to the inverse of the latched program bit 7.
- R4: A read that starts while busy during an erase (erase flag 1) returns bit 7 equal to 0.
- R5: While busy, the first read after the busy rising edge returns bit 6 = 0, and each following read start returns the inverse of the previous read's bit 6.
- R6: A read strobe held high for several cycles during busy counts as one read: the output stays fixed for the whole hold and bit 6 advances only once.
- R7: During busy, every bit other than 7 and 6 of a read equals the array word present at the cycle the read starts.
- R8: While not busy and the read strobe is high, the output equals the array word of the previous cycle, tracking it every cycle.
- R9: Each busy rising edge restarts bit 6, so the first read of a new operation returns 0 whatever count the previous operation ended on.
- R10: While the read strobe is low, the data output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | 1 = erase running, 0 = program running |
| prog_d7_i | input | 1 | Latched bit 7 of the word being programmed |
| rd_strobe_i | input | 1 | Read strobe, high for the length of a read |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output select, active low |
| array_word_i | input | W | Current array word at the read address |
| dq_o | output | W | Read data or status word |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
Every result is registered once: the read word appears one clock after the edge that sees the strobe rise (or, when idle, one clock after each strobed cycle), and the output enable one clock after chip and output select change. The bench drives inputs on the falling edge and samples on the next falling edge, which lies exactly one rising edge later, so each check lands in the first cycle its value is due. Held-strobe and strobe-low checks sample over several cycles while the array word changes under them, to show that nothing is reloaded.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

    localparam int unsigned POLL_BIT = 7;
    localparam int unsigned TOG_BIT  = 6;

    typedef struct packed {
        logic rd;
        logic busy;
    } edge_st_t;

    typedef struct packed {
        logic tog;
    } tog_st_t;

endpackage

// File: rtl/wstat_edge.sv
module wstat_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe_i,
    input  logic busy_i,
    output logic rd_start_o,
    output logic busy_rise_o
);
    import wstat_pkg::*;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.rd     = rd_strobe_i;
        st_d.busy   = busy_i;
        rd_start_o  = rd_strobe_i & ~st_q.rd;
        busy_rise_o = busy_i & ~st_q.busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle #(
    parameter logic TOG_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic advance_i,
    output logic tog_o
);
    import wstat_pkg::*;

    tog_st_t st_d, st_q;

    always_comb begin
        tog_o    = restart_i ? TOG_INIT : st_q.tog;
        st_d.tog = tog_o ^ advance_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.tog <= TOG_INIT;
        else        st_q     <= st_d;
    end
endmodule

// File: rtl/wstat_mux.sv
module wstat_mux #(
    parameter int unsigned W = 16
) (
    input  logic         op_erase_i,
    input  logic         prog_d7_i,
    input  logic         tog_i,
    input  logic [W-1:0] array_word_i,
    output logic [W-1:0] status_o
);
    import wstat_pkg::*;

    always_comb begin
        status_o           = array_word_i;
        status_o[POLL_BIT] = op_erase_i ? 1'b0 : ~prog_d7_i;
        status_o[TOG_BIT]  = tog_i;
    end
endmodule

// File: rtl/wstat_gen.sv
module wstat_gen #(
    parameter int unsigned W        = 16,
    parameter logic        TOG_INIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy_i,
    input  logic         op_erase_i,
    input  logic         prog_d7_i,
    input  logic         rd_strobe_i,
    input  logic         ce_n_i,
    input  logic         oe_n_i,
    input  logic [W-1:0] array_word_i,
    output logic [W-1:0] dq_o,
    output logic         dq_oe_o
);
    typedef struct packed {
        logic [W-1:0] dq;
        logic         oe;
    } out_st_t;

    out_st_t      st_d, st_q;
    logic         rd_start, busy_rise, tog_now;
    logic [W-1:0] status_word;

    wstat_edge i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_strobe_i(rd_strobe_i),
        .busy_i     (busy_i),
        .rd_start_o (rd_start),
        .busy_rise_o(busy_rise)
    );

    wstat_toggle #(.TOG_INIT(TOG_INIT)) i_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(busy_rise),
        .advance_i(rd_start & busy_i),
        .tog_o    (tog_now)
    );

    wstat_mux #(.W(W)) i_mux (
        .op_erase_i  (op_erase_i),
        .prog_d7_i   (prog_d7_i),
        .tog_i       (tog_now),
        .array_word_i(array_word_i),
        .status_o    (status_word)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = ~ce_n_i & ~oe_n_i;
        if (rd_strobe_i && !busy_i)
            st_d.dq = array_word_i;
        else if (rd_start && busy_i)
            st_d.dq = status_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_o    = st_q.dq;
    assign dq_oe_o = st_q.oe;
endmodule

// File: rtl/wstat_chk.sv
module wstat_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy_i,
    input logic         op_erase_i,
    input logic         prog_d7_i,
    input logic         rd_strobe_i,
    input logic         ce_n_i,
    input logic         oe_n_i,
    input logic [W-1:0] array_word_i,
    input logic [W-1:0] dq_o,
    input logic         dq_oe_o
);
    logic rd_prev, busy_prev, seen_q, capture_q, last6_q;
    logic rd_start, busy_rise;

    assign rd_start  = rd_strobe_i & ~rd_prev;
    assign busy_rise = busy_i & ~busy_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev   <= 1'b0;
            busy_prev <= 1'b0;
            seen_q    <= 1'b0;
            capture_q <= 1'b0;
            last6_q   <= 1'b0;
        end else begin
            rd_prev   <= rd_strobe_i;
            busy_prev <= busy_i;
            capture_q <= rd_start & busy_i;
            if (capture_q) last6_q <= dq_o[6];
            if (!busy_i || busy_rise) seen_q <= rd_start & busy_i;
            else if (rd_start)        seen_q <= 1'b1;
        end
    end

    initial begin
        assert (W >= 8) else $error("data width must hold bits 7 and 6");
    end

    p_oe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dq_oe_o == $past(~ce_n_i & ~oe_n_i));

    p_poll_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy_i && !op_erase_i) |=> dq_o[7] == ~$past(prog_d7_i));

    p_poll_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy_i && op_erase_i) |=> dq_o[7] == 1'b0);

    p_first_tog_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy_rise) |=> dq_o[6] == 1'b0);

    p_tog_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy_i && !busy_rise && seen_q) |=> dq_o[6] == ~last6_q);

    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && rd_prev && busy_i) |=> $stable(dq_o));

    p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy_i) |=> dq_o[5:0] == $past(array_word_i[5:0]));

    p_idle_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && !busy_i) |=> dq_o == $past(array_word_i));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_i |=> $stable(dq_o));
endmodule

bind wstat_gen wstat_chk #(.W(W)) i_wstat_chk (.*);

// File: tb/test_wstat_gen.sv
module test_wstat_gen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy_i = 1'b0, op_erase_i = 1'b0, prog_d7_i = 1'b0;
    logic         rd_strobe_i = 1'b0, ce_n_i = 1'b1, oe_n_i = 1'b1;
    logic [W-1:0] array_word_i = '0;
    logic [W-1:0] dq_o;
    logic         dq_oe_o;

    int checks = 0, errors = 0;
    logic done = 1'b0;
    logic exp_tog;

    always #2 clk = ~clk;

    wstat_gen #(.W(W)) i_wstat_gen (.*);

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [W-1:0] status(logic [W-1:0] arr, logic er, logic d7, logic t);
        logic [W-1:0] s = arr;
        s[7] = er ? 1'b0 : ~d7;
        s[6] = t;
        return s;
    endfunction

    task automatic start_op(logic er, logic d7);
        @(negedge clk);
        busy_i = 1'b1; op_erase_i = er; prog_d7_i = d7;
        exp_tog = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_op();
        @(negedge clk);
        busy_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic busy_read(string req, logic [W-1:0] arr);
        @(negedge clk);
        array_word_i = arr; rd_strobe_i = 1'b1;
        @(negedge clk);
        check(req, dq_o, status(arr, op_erase_i, prog_d7_i, exp_tog));
        exp_tog = ~exp_tog;
        rd_strobe_i = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 dq", dq_o, '0);
        check("R1 oe", {15'd0, dq_oe_o}, '0);
        rst_n = 1'b1;

        // R2: output enable sweep over both selects
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ce_n_i = k[0]; oe_n_i = k[1];
            @(negedge clk);
            check("R2 oe", {15'd0, dq_oe_o}, {15'd0, (k == 0)});
        end

        // R8: idle reads pass array data and track it while held
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            array_word_i = 16'h1357 * (k + 3) ^ 16'h00C0 * k;
            rd_strobe_i  = 1'b1;
            @(negedge clk);
            check("R8 idle pass", dq_o, 16'h1357 * (k + 3) ^ 16'h00C0 * k);
        end
        rd_strobe_i = 1'b0;

        // R3 R4 R5 R7: sweep op kind, program bit and four reads each
        for (int er = 0; er < 2; er++)
            for (int d7 = 0; d7 < 2; d7++) begin
                start_op(er[0], d7[0]);
                for (int r = 0; r < 4; r++) begin
                    @(negedge clk);
                    busy_read(er ? "R4 R5 R7 erase read" : "R3 R5 R7 program read",
                              16'hA5C3 ^ (16'h0101 * (r + 4 * d7 + 8 * er)));
                end
                end_op();
            end

        // R6: long read during busy holds and counts once
        start_op(1'b0, 1'b1);
        @(negedge clk);
        array_word_i = 16'h5AF0; rd_strobe_i = 1'b1;
        @(negedge clk);
        held = status(16'h5AF0, 1'b0, 1'b1, 1'b0);
        check("R6 hold start", dq_o, held);
        for (int c = 0; c < 5; c++) begin
            array_word_i = 16'hFFFF - c[15:0];
            @(negedge clk);
            check("R6 hold stable", dq_o, held);
        end
        rd_strobe_i = 1'b0;
        exp_tog = 1'b1;
        @(negedge clk);
        busy_read("R6 one count", 16'h0F3C);

        // R10: strobe low holds output while inputs move
        held = status(16'h0F3C, 1'b0, 1'b1, 1'b1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            array_word_i = 16'h1111 * c[15:0]; op_erase_i = c[0]; prog_d7_i = c[1];
            @(negedge clk);
            check("R10 quiet", dq_o, held);
        end

        // R9: odd number of reads, then new operation restarts at 0
        op_erase_i = 1'b0; prog_d7_i = 1'b1;
        busy_read("R5 odd count", 16'h2222);
        end_op();
        start_op(1'b1, 1'b0);
        busy_read("R9 restart", 16'h3C3C);
        busy_read("R9 second", 16'h4C4C);

        // R8: after completion a read returns true array data
        end_op();
        @(negedge clk);
        array_word_i = 16'hFFFF; rd_strobe_i = 1'b1;
        @(negedge clk);
        check("R8 after erase", dq_o, 16'hFFFF);
        rd_strobe_i = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule